// File: doc/BRIEF.md
# Dual-Channel FIFO Ready Signalling

This block produces the active-low transmit-ready and receive-ready strobes that a DMA engine watches for each of two serial channels. It also produces one status byte that gathers every channel's ready indications so that software can poll them in one read. It does not hold FIFO storage. It takes the fill counts of the 64-entry transmit and receive FIFOs, the programmed trigger settings, a FIFO-enable bit and the receive error flag, and turns them into registered handshake levels.

The transmit trigger comes from a fine-grained trigger register, counted in units of four entries. If that register is zero, a two-bit legacy selector chooses from four fixed levels instead. A channel's transmit side requests data when it has at least that many free entries or when it is empty. A channel's receive side requests service when it holds at least one character and no receive error is flagged. When the FIFOs are disabled, each side behaves like a single-byte holding register.

Top module: `fifo_dma_ready`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every `*_rdy_n` output is 1 (inactive) and `rdy_status` is 8'h00.
- R2: In FIFO mode, `tx_rdy_n[c]` is 0 whenever the free space (64 minus `tx_count[c]`) is at least the effective trigger, and 1 when it is below the trigger and the FIFO is not empty.
- R3: In FIFO mode, `tx_rdy_n[c]` is 0 whenever `tx_count[c]` is 0, whatever the trigger.
- R4: When `tx_trig_q4[c]` is nonzero, the effective trigger is 4 times its value (4 to 60).
- R5: When `tx_trig_q4[c]` is zero, the effective trigger is taken from `tx_trig_sel[c]`: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 56.
- R6: With `rx_err[c]` at 0, `rx_rdy_n[c]` is 0 exactly when `rx_count[c]` is at least 1, in both FIFO and non-FIFO mode.
- R7: `rx_rdy_n[c]` is 1 whenever `rx_err[c]` is 1, whatever the fill count.
- R8: With `fifo_en[c]` at 0, `tx_rdy_n[c]` is 0 exactly when `tx_count[c]` is 0, and the trigger inputs have no effect.
- R9: `rdy_status` bit 0 is channel A transmit ready and bit 1 is channel B transmit ready. Bit 4 is channel A receive ready and bit 5 is channel B receive ready. 1 means ready, which is the inverse of the matching `*_rdy_n`. Bits 3:2 and 7:6 are always 0.
- R10: Each output reflects the inputs sampled at the previous rising clock edge, so there is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 2 | FIFO mode enable per channel |
| tx_count | input | 2x7 | Transmit FIFO fill count per channel (0..64) |
| rx_count | input | 2x7 | Receive FIFO fill count per channel (0..64) |
| tx_trig_q4 | input | 2x4 | Fine trigger setting, level divided by four; 0 selects legacy |
| tx_trig_sel | input | 2x2 | Legacy trigger selector per channel |
| rx_err | input | 2 | Receive error flag per channel |
| tx_rdy_n | output | 2 | Active-low transmit DMA ready per channel |
| rx_rdy_n | output | 2 | Active-low receive DMA ready per channel |
| rdy_status | output | 8 | Packed ready status byte |

## Verification
The assertions assume that the fill counts never exceed the FIFO depth of 64. They also assume that inputs change only between clock edges, since every implication is stated against the value registered one edge later. The stimulus drives every input at the falling edge and keeps each count in the range 0..64. Both channels are swept together over all trigger codes, both modes and every fill level, and the two channels get different patterns so that a crossed lane would show up.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int TRIG_STEP  = 4;

  // legacy selector to trigger level
  function automatic int legacy_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

  // fine setting wins when nonzero
  function automatic int resolve_level(input int q4, input logic [1:0] sel);
    if (q4 != 0) return q4 * TRIG_STEP;
    return legacy_level(sel);
  endfunction

  function automatic logic tx_wants(input logic fe, input int cnt,
                                    input int depth, input int trig);
    if (!fe) return (cnt == 0);
    return (cnt == 0) || ((depth - cnt) >= trig);
  endfunction

  function automatic logic rx_wants(input int cnt, input logic err);
    return (cnt != 0) && !err;
  endfunction
endpackage

// File: rtl/rdy_trig_resolve.sv
module rdy_trig_resolve #(
  parameter int DEPTH = rdy_pkg::FIFO_DEPTH,
  parameter int Q4_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [Q4_W-1:0]  trig_q4,
  input  logic [1:0]       trig_sel,
  output logic [CNT_W-1:0] trig_level
);
  import rdy_pkg::*;

  always_comb begin
    trig_level = CNT_W'(resolve_level(int'(trig_q4), trig_sel));
    AST_TRIG_RANGE: assert (trig_level != '0 && int'(trig_level) <= DEPTH); // R4
  end
endmodule

// File: rtl/rdy_channel.sv
module rdy_channel #(
  parameter int DEPTH = rdy_pkg::FIFO_DEPTH,
  parameter int Q4_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [Q4_W-1:0]  trig_q4,
  input  logic [1:0]       trig_sel,
  input  logic             rx_err,
  output logic             tx_rdy_n,
  output logic             rx_rdy_n
);
  import rdy_pkg::*;

  logic [CNT_W-1:0] trig_level;
  logic             tx_want;
  logic             rx_want;
  logic             tx_empty;
  logic             tx_full;

  rdy_trig_resolve #(.DEPTH(DEPTH), .Q4_W(Q4_W)) u_resolve (
    .trig_q4    (trig_q4),
    .trig_sel   (trig_sel),
    .trig_level (trig_level)
  );

  assign tx_empty = (tx_count == '0);
  assign tx_full  = (int'(tx_count) == DEPTH);
  assign tx_want  = tx_wants(fifo_en, int'(tx_count), DEPTH, int'(trig_level));
  assign rx_want  = rx_wants(int'(rx_count), rx_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rdy_n <= 1'b1;
      rx_rdy_n <= 1'b1;
    end else begin
      tx_rdy_n <= !tx_want;
      rx_rdy_n <= !rx_want;
    end
  end

  AST_TX_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |=> !tx_rdy_n); // R3
  AST_TX_FULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |=> tx_rdy_n); // R2
  AST_RX_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> rx_rdy_n); // R6
  AST_RX_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> rx_rdy_n); // R7
  AST_NOFIFO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !tx_empty) |=> tx_rdy_n); // R8
endmodule

// File: rtl/rdy_status_pack.sv
module rdy_status_pack #(
  parameter int NUM_CH = 2,
  parameter int RX_BASE = 4
) (
  input  logic [NUM_CH-1:0] tx_rdy_n,
  input  logic [NUM_CH-1:0] rx_rdy_n,
  output logic [7:0]        status
);
  always_comb begin
    status = 8'h00;
    for (int c = 0; c < NUM_CH; c++) begin
      status[c]           = !tx_rdy_n[c];
      status[RX_BASE + c] = !rx_rdy_n[c];
    end
  end
endmodule

// File: rtl/fifo_dma_ready.sv
module fifo_dma_ready #(
  parameter int DEPTH  = rdy_pkg::FIFO_DEPTH,
  parameter int Q4_W   = 4,
  parameter int NUM_CH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            fifo_en,
  input  logic [NUM_CH-1:0][CNT_W-1:0] tx_count,
  input  logic [NUM_CH-1:0][CNT_W-1:0] rx_count,
  input  logic [NUM_CH-1:0][Q4_W-1:0]  tx_trig_q4,
  input  logic [NUM_CH-1:0][1:0]       tx_trig_sel,
  input  logic [NUM_CH-1:0]            rx_err,
  output logic [NUM_CH-1:0]            tx_rdy_n,
  output logic [NUM_CH-1:0]            rx_rdy_n,
  output logic [7:0]                   rdy_status
);
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      rdy_channel #(.DEPTH(DEPTH), .Q4_W(Q4_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en[c]),
        .tx_count (tx_count[c]),
        .rx_count (rx_count[c]),
        .trig_q4  (tx_trig_q4[c]),
        .trig_sel (tx_trig_sel[c]),
        .rx_err   (rx_err[c]),
        .tx_rdy_n (tx_rdy_n[c]),
        .rx_rdy_n (rx_rdy_n[c])
      );
    end
  endgenerate

  rdy_status_pack #(.NUM_CH(NUM_CH), .RX_BASE(4)) u_pack (
    .tx_rdy_n (tx_rdy_n),
    .rx_rdy_n (rx_rdy_n),
    .status   (rdy_status)
  );

  AST_STATUS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_status[3:2] == 2'b00) && (rdy_status[7:6] == 2'b00)); // R9
endmodule

// File: tb/tb_fifo_dma_ready.sv
module tb_fifo_dma_ready;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]      fifo_en = '0;
  logic [1:0][6:0] tx_count = '0;
  logic [1:0][6:0] rx_count = '0;
  logic [1:0][3:0] tx_trig_q4 = '0;
  logic [1:0][1:0] tx_trig_sel = '0;
  logic [1:0]      rx_err = '0;
  logic [1:0]      tx_rdy_n;
  logic [1:0]      rx_rdy_n;
  logic [7:0]      rdy_status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  fifo_dma_ready dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bench_trig(input int q4, input int sel);
    int t;
    t = 8 << sel;
    if (sel == 3) t = 56;
    if (q4 > 0) t = q4 + q4 + q4 + q4;
    return t;
  endfunction

  function automatic int exp_tx_n(input int fe, input int cnt, input int q4, input int sel);
    if (cnt == 0) return 0;
    if (fe == 0) return 1;
    return (64 - cnt < bench_trig(q4, sel)) ? 1 : 0;
  endfunction

  function automatic int exp_rx_n(input int cnt, input int err);
    return (cnt >= 1 && err == 0) ? 0 : 1;
  endfunction

  function automatic string tx_tag(input int fe, input int cnt, input int q4);
    if (fe == 0) return "R8";
    if (cnt == 0) return "R3";
    if (q4 == 0) return "R5";
    return "R2_R4";
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tx_rdy_n in reset", int'(tx_rdy_n), 3);
    check("R1 rx_rdy_n in reset", int'(rx_rdy_n), 3);
    check("R1 status in reset", int'(rdy_status), 0);
    tx_count[0] = 7'd1; rx_count[0] = 7'd5; fifo_en = 2'b11;
    rst_n = 1'b1;
    check("R1 held after release", int'(rx_rdy_n), 3);

    // R10: an input change is visible only after the next rising edge
    @(negedge clk);
    check("R10 settled rx", int'(rx_rdy_n[0]), 0);
    rx_err[0] = 1'b1;
    #1 check("R10 before edge", int'(rx_rdy_n[0]), 0);
    @(negedge clk);
    check("R10 after edge", int'(rx_rdy_n[0]), 1);
    rx_err[0] = 1'b0;

    for (int fe = 0; fe < 2; fe++)
      for (int q4 = 0; q4 < 16; q4++)
        for (int sel = 0; sel < 4; sel++)
          for (int cnt = 0; cnt <= 64; cnt++) begin
            int cb, rb, ea, eb;
            cb = 64 - cnt;
            rb = (cnt * 3) % 65;
            ea = (cnt % 7 == 3) ? 1 : 0;
            eb = (cnt % 5 == 1) ? 1 : 0;
            fifo_en = {fe[0], fe[0]};
            tx_count[0] = 7'(cnt); tx_count[1] = 7'(cb);
            rx_count[0] = 7'(cnt); rx_count[1] = 7'(rb);
            tx_trig_q4[0] = 4'(q4); tx_trig_q4[1] = 4'(15 - q4);
            tx_trig_sel[0] = 2'(sel); tx_trig_sel[1] = 2'(3 - sel);
            rx_err = {eb[0], ea[0]};
            @(negedge clk);
            begin
              int ta, tb_n, ra, rbn, st;
              ta   = exp_tx_n(fe, cnt, q4, sel);
              tb_n = exp_tx_n(fe, cb, 15 - q4, 3 - sel);
              ra   = exp_rx_n(cnt, ea);
              rbn  = exp_rx_n(rb, eb);
              check({tx_tag(fe, cnt, q4), " tx A"}, int'(tx_rdy_n[0]), ta);
              check({tx_tag(fe, cb, 15 - q4), " tx B"}, int'(tx_rdy_n[1]), tb_n);
              check(ea ? "R7 rx A" : "R6 rx A", int'(rx_rdy_n[0]), ra);
              check(eb ? "R7 rx B" : "R6 rx B", int'(rx_rdy_n[1]), rbn);
              st = (1 - ta) + 2 * (1 - tb_n) + 16 * (1 - ra) + 32 * (1 - rbn);
              check("R9 status", int'(rdy_status), st);
            end
          end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule